// File: doc/BRIEF.md
# Windowed Program Bank Address Translator

This block sits between a CPU's upper address range (0x6000 to 0xFFFF) and a banked program store. The range is cut into a fixed table of contiguous windows. Each window is empty, ROM, RAM, a small work RAM held inside the block, or a mirror of another window. For every CPU address the block finds the window and the offset inside it. It then resolves a bank number, either fixed or taken from a bank-select register. From these it forms a physical store address and decides how the access behaves.

RAM windows carry a two-bit access status. Code 0 is disabled, code 1 reads as zero, code 2 is read-only and code 3 is read-write. This status decides whether a read returns the stored byte, returns zero or leaves the bus floating. It also decides whether a write is committed. Translation is combinational. Writes to the external store come out as a registered write enable, write address and write data one clock after the strobe. Register programming sits outside the block.

The default table, with 4 KiB banks and 12 banks present, is laid out as follows:

| Window | Range | Content |
|---|---|---|
| 0 | 0x6000-0x67FF | work RAM, status slot 0 |
| 1 | 0x6800-0x6FFF | empty |
| 2 | 0x7000-0x7FFF | mirror of window 5 |
| 3 | 0x8000-0x9FFF | ROM, select register 0 |
| 4 | 0xA000-0xAFFF | RAM, fixed bank 2, no status slot |
| 5 | 0xB000-0xBFFF | RAM, select register 1, status slot 1 |
| 6 | 0xC000-0xDFFF | ROM, select register 2 |
| 7 | 0xE000-0xFFFF | ROM, fixed at the last bank |

Top module: `prg_bank_xlat`

## Requirements
- R1: Every address from 0x6000 to 0xFFFF falls in exactly one window, the one with the highest start at or below it. The offset is the address minus that start. For ROM and RAM windows, `mem_addr` = bank × 4096 + offset. Otherwise `mem_addr` is 0.
- R2: A switchable window takes its bank from its 8-bit select register in `bank_sel`. Register n is bits [8n+7:8n]. The value is reduced modulo the bank count, 12. A fixed window takes a constant bank. The "last bank" constant resolves to bank count − 1.
- R3: For a ROM or RAM window that spans m banks, the bank is ANDed with the complement of (m >> 1). The 8 KiB windows 3, 6 and 7 therefore always use an even bank.
- R4: `ram_status` slot s is bits [2s+1:2s]. While `cpu_rd` is high, the slot's code controls the read. Code 0 raises `open_bus`. Code 1 raises `rd_zero` with `cpu_rdata` = 0. Code 2 or 3 returns the stored byte with both flags low.
- R5: A write to the external store is committed only when the window's status is read-write (code 3). It appears as `mem_we` high in the cycle after `cpu_wr`, with `mem_waddr` equal to the translated address and `mem_wdata` equal to the written byte.
- R6: ROM windows read as read-only. Writes to them never raise `mem_we`.
- R7: Empty windows and addresses below 0x6000 raise `open_bus` on reads and ignore writes.
- R8: A mirror window uses the bank, the type and the status of the window it names, with its own offset.
- R9: A RAM window that has no status slot behaves as read-write.
- R10: Work RAM is held inside the block and indexed by the window offset. It obeys its status slot. A write under code 2 leaves the stored byte unchanged. A write under code 3 replaces it.
- R11: During and after reset `mem_we` is low. While `cpu_rd` is low, `open_bus` and `rd_zero` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | CPU write data |
| bank_sel | input | NUM_SEL*SEL_W | Bank-select registers, packed |
| ram_status | input | NUM_SLOT*2 | RAM status codes, packed |
| mem_rdata | input | 8 | Byte from the store at `mem_addr` |
| mem_addr | output | MEM_AW | Translated store address |
| mem_we | output | 1 | Registered store write enable |
| mem_waddr | output | MEM_AW | Registered store write address |
| mem_wdata | output | 8 | Registered store write data |
| cpu_rdata | output | 8 | Read data to the CPU |
| rd_zero | output | 1 | Read forced to zero |
| open_bus | output | 1 | Read not driven; the bus keeps its last value |

## Verification
The bench sweeps the first and last byte of every 64-byte block over the whole range. It does this under all sixteen status pairs and two sets of bank selections. The selections include values at and above the bank count, and an odd "last" bank that must come out even. A design that picked windows by the lowest start, or that dropped the modulo, would give wrong store addresses. So would a design that left bit 0 set in an 8 KiB window. A wrong mirror would show up as fixed-bank addresses or as ignored status codes at 0x7000 to 0x7FFF. Directed writes cover every status code, ROM, empty space and work RAM. A design that committed writes under read-only or read-as-zero would raise `mem_we` or change a work RAM byte that the bench reads back.

// File: rtl/prg_xlat_pkg.sv
package prg_xlat_pkg;

  typedef enum logic [2:0] {
    WK_EMPTY  = 3'd0,
    WK_ROM    = 3'd1,
    WK_RAM    = 3'd2,
    WK_WRAM   = 3'd3,
    WK_MIRROR = 3'd4
  } win_kind_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ZERO = 2'd1,
    ST_RO   = 2'd2,
    ST_RW   = 2'd3
  } ram_status_e;

  localparam int NUM_WIN    = 8;
  localparam int WIN_IW     = $clog2(NUM_WIN);
  localparam int SPACE_BASE = 'h6000;

  typedef struct packed {
    logic [15:0]       start;
    win_kind_e         kind;
    logic              switchable;
    logic              from_end;
    logic [7:0]        fixed_bank;
    logic [1:0]        sel_id;
    logic              has_status;
    logic              status_id;
    logic [WIN_IW-1:0] target;
  } win_desc_t;

  // Window table: contiguous, first start 0x6000, last window runs to 0xFFFF.
  function automatic win_desc_t win_desc(input int idx);
    win_desc_t d;
    d = '0;
    case (idx)
      0: begin d.start = 16'h6000; d.kind = WK_WRAM; d.has_status = 1'b1; d.status_id = 1'b0; end
      1: begin d.start = 16'h6800; d.kind = WK_EMPTY; end
      2: begin d.start = 16'h7000; d.kind = WK_MIRROR; d.target = WIN_IW'(5); end
      3: begin d.start = 16'h8000; d.kind = WK_ROM; d.switchable = 1'b1; d.sel_id = 2'd0; end
      4: begin d.start = 16'hA000; d.kind = WK_RAM; d.fixed_bank = 8'd2; end
      5: begin d.start = 16'hB000; d.kind = WK_RAM; d.switchable = 1'b1; d.sel_id = 2'd1;
               d.has_status = 1'b1; d.status_id = 1'b1; end
      6: begin d.start = 16'hC000; d.kind = WK_ROM; d.switchable = 1'b1; d.sel_id = 2'd2; end
      7: begin d.start = 16'hE000; d.kind = WK_ROM; d.from_end = 1'b1; end
      default: d.kind = WK_EMPTY;
    endcase
    return d;
  endfunction

  function automatic logic [16:0] win_start(input int idx);
    win_desc_t d;
    d = win_desc(idx);
    return {1'b0, d.start};
  endfunction

  function automatic logic [16:0] win_size(input int idx);
    logic [16:0] stop;
    stop = (idx >= NUM_WIN - 1) ? 17'h10000 : win_start(idx + 1);
    return stop - win_start(idx);
  endfunction

  // Clear the low bank bit(s) for a window spanning several banks.
  function automatic int bank_align(input int bank, input int mult);
    return bank & ~(mult >> 1);
  endfunction

  function automatic int phys_addr(input int bank, input int offset, input int bank_log2);
    return (bank << bank_log2) + offset;
  endfunction

endpackage

// File: rtl/prg_window_decode.sv
module prg_window_decode
  import prg_xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  output logic              in_space,
  output logic [WIN_IW-1:0] win_idx,
  output logic [WIN_IW-1:0] src_idx,
  output logic [15:0]       win_off,
  output logic              src_is_mirror
);

  logic [NUM_WIN-1:0] hit;
  win_desc_t          wd;
  win_desc_t          sd;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WIN; gi++) begin : g_hit
      assign hit[gi] = ({1'b0, cpu_addr} >= win_start(gi)) &&
                       ({1'b0, cpu_addr} <  (win_start(gi) + win_size(gi)));
    end
  endgenerate

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit[i]) win_idx = WIN_IW'(i);
    end
    in_space      = |hit;
    wd            = win_desc(int'(win_idx));
    win_off       = cpu_addr - wd.start;
    src_idx       = (wd.kind == WK_MIRROR) ? wd.target : win_idx;
    sd            = win_desc(int'(src_idx));
    src_is_mirror = (sd.kind == WK_MIRROR);
  end

  assert_single_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  assert_space_cover_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'(SPACE_BASE)) |-> in_space);
  assert_offset_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_space |-> ({1'b0, win_off} < win_size(int'(win_idx))));
  assert_mirror_resolved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_space |-> !src_is_mirror);

endmodule

// File: rtl/prg_bank_resolve.sv
module prg_bank_resolve
  import prg_xlat_pkg::*;
#(
  parameter int BANK_LOG2  = 12,
  parameter int BANK_COUNT = 12,
  parameter int SEL_W      = 8,
  parameter int NUM_SEL    = 3,
  parameter int MEM_AW     = 16,
  parameter int BIDX_W     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_space,
  input  logic [WIN_IW-1:0]        src_idx,
  input  logic [15:0]              win_off,
  input  logic [NUM_SEL*SEL_W-1:0] bank_sel,
  output logic [BIDX_W-1:0]        bank_idx,
  output logic [7:0]               bank_mult,
  output logic                     banked,
  output logic [MEM_AW-1:0]        phys
);

  win_desc_t d;
  int        raw;
  int        red;
  int        mult;

  always_comb begin
    d   = win_desc(int'(src_idx));
    raw = 0;
    if (d.switchable) begin
      for (int s = 0; s < NUM_SEL; s++) begin
        if (int'(d.sel_id) == s) raw = int'(bank_sel[s*SEL_W +: SEL_W]);
      end
    end else begin
      raw = int'(d.fixed_bank);
    end
    red = raw % BANK_COUNT;
    if (d.from_end) red = BANK_COUNT - 1;
    mult      = int'(win_size(int'(src_idx))) >> BANK_LOG2;
    red       = bank_align(red, mult);
    bank_idx  = BIDX_W'(red);
    bank_mult = 8'(mult);
    banked    = in_space && ((d.kind == WK_ROM) || (d.kind == WK_RAM));
    phys      = MEM_AW'(phys_addr(red, int'(win_off), BANK_LOG2));
  end

  assert_bank_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    banked |-> (int'(bank_idx) < BANK_COUNT));
  assert_pair_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (banked && (bank_mult == 8'd2)) |-> !bank_idx[0]);

endmodule

// File: rtl/prg_access_ctrl.sv
module prg_access_ctrl
  import prg_xlat_pkg::*;
#(
  parameter int NUM_SLOT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_space,
  input  logic [WIN_IW-1:0]     src_idx,
  input  logic                  cpu_rd,
  input  logic [NUM_SLOT*2-1:0] ram_status,
  output win_kind_e             kind,
  output ram_status_e           eff_status,
  output logic                  readable,
  output logic                  rd_open,
  output logic                  rd_zero,
  output logic                  wr_allowed
);

  win_desc_t   d;
  ram_status_e slot_st;

  always_comb begin
    d       = win_desc(int'(src_idx));
    kind    = in_space ? d.kind : WK_EMPTY;
    slot_st = ST_RW;
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (int'(d.status_id) == s) slot_st = ram_status_e'(ram_status[2*s +: 2]);
    end
    case (kind)
      WK_ROM:          eff_status = ST_RO;
      WK_RAM, WK_WRAM: eff_status = d.has_status ? slot_st : ST_RW;
      default:         eff_status = ST_OFF;
    endcase
    readable   = (eff_status == ST_RO) || (eff_status == ST_RW);
    rd_open    = cpu_rd && (eff_status == ST_OFF);
    rd_zero    = cpu_rd && (eff_status == ST_ZERO);
    wr_allowed = (eff_status == ST_RW);
  end

  assert_rom_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_ROM) |-> (!wr_allowed && readable));
  assert_idle_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> (!rd_open && !rd_zero));

endmodule

// File: rtl/prg_work_ram.sv
module prg_work_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/prg_bank_xlat.sv
module prg_bank_xlat
  import prg_xlat_pkg::*;
#(
  parameter int BANK_LOG2  = 12,
  parameter int BANK_COUNT = 12,
  parameter int SEL_W      = 8,
  parameter int NUM_SEL    = 3,
  parameter int NUM_SLOT   = 2,
  parameter int WRAM_LOG2  = 11,
  parameter int BIDX_W     = $clog2(BANK_COUNT),
  parameter int MEM_AW     = BIDX_W + BANK_LOG2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [15:0]              cpu_addr,
  input  logic                     cpu_rd,
  input  logic                     cpu_wr,
  input  logic [7:0]               cpu_wdata,
  input  logic [NUM_SEL*SEL_W-1:0] bank_sel,
  input  logic [NUM_SLOT*2-1:0]    ram_status,
  input  logic [7:0]               mem_rdata,
  output logic [MEM_AW-1:0]        mem_addr,
  output logic                     mem_we,
  output logic [MEM_AW-1:0]        mem_waddr,
  output logic [7:0]               mem_wdata,
  output logic [7:0]               cpu_rdata,
  output logic                     rd_zero,
  output logic                     open_bus
);

  logic              in_space;
  logic [WIN_IW-1:0] win_idx;
  logic [WIN_IW-1:0] src_idx;
  logic [15:0]       win_off;
  logic              src_is_mirror;
  logic [BIDX_W-1:0] bank_idx;
  logic [7:0]        bank_mult;
  logic              banked;
  logic [MEM_AW-1:0] phys;
  win_kind_e         kind;
  ram_status_e       eff_status;
  logic              readable;
  logic              wr_allowed;
  logic              is_wram;
  logic              wram_we;
  logic              ext_write;
  logic [7:0]        wram_q;

  prg_window_decode u_decode (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .in_space(in_space),
    .win_idx(win_idx), .src_idx(src_idx), .win_off(win_off),
    .src_is_mirror(src_is_mirror)
  );

  prg_bank_resolve #(
    .BANK_LOG2(BANK_LOG2), .BANK_COUNT(BANK_COUNT), .SEL_W(SEL_W),
    .NUM_SEL(NUM_SEL), .MEM_AW(MEM_AW), .BIDX_W(BIDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .in_space(in_space), .src_idx(src_idx),
    .win_off(win_off), .bank_sel(bank_sel), .bank_idx(bank_idx),
    .bank_mult(bank_mult), .banked(banked), .phys(phys)
  );

  prg_access_ctrl #(.NUM_SLOT(NUM_SLOT)) u_access (
    .clk(clk), .rst_n(rst_n), .in_space(in_space), .src_idx(src_idx),
    .cpu_rd(cpu_rd), .ram_status(ram_status), .kind(kind),
    .eff_status(eff_status), .readable(readable), .rd_open(open_bus),
    .rd_zero(rd_zero), .wr_allowed(wr_allowed)
  );

  assign is_wram   = (kind == WK_WRAM);
  assign wram_we   = cpu_wr && wr_allowed && is_wram;
  assign ext_write = cpu_wr && wr_allowed && banked;

  prg_work_ram #(.AW(WRAM_LOG2)) u_wram (
    .clk(clk), .we(wram_we), .addr(win_off[WRAM_LOG2-1:0]),
    .wdata(cpu_wdata), .rdata(wram_q)
  );

  assign mem_addr  = banked ? phys : '0;
  assign cpu_rdata = !readable ? 8'h00 : (is_wram ? wram_q : mem_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= ext_write;
      if (ext_write) begin
        mem_waddr <= phys;
        mem_wdata <= cpu_wdata;
      end
    end
  end

  assert_write_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(cpu_wr) && ($past(eff_status) == ST_RW)));
  assert_write_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_waddr == $past(mem_addr)));
  assert_zero_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |-> (cpu_rdata == 8'h00));
  assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_zero && open_bus));
  assert_empty_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && (kind == WK_EMPTY)) |=> !mem_we);
  assert_rom_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && (kind == WK_ROM)) |=> !mem_we);

endmodule

// File: tb/prg_bank_xlat_bench.sv
`timescale 1ns/100ps
module prg_bank_xlat_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = 8'h0;
  logic [23:0] bank_sel = '0;
  logic [3:0]  ram_status = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_waddr;
  logic [7:0]  mem_wdata;
  logic [7:0]  cpu_rdata;
  logic        rd_zero;
  logic        open_bus;

  int checks = 0;
  int errors = 0;
  logic [7:0] wram_model [0:2047];
  bit         written    [0:2047];

  always #2.5 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8];

  prg_bank_xlat u_prg_bank_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .bank_sel(bank_sel),
    .ram_status(ram_status), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .cpu_rdata(cpu_rdata), .rd_zero(rd_zero), .open_bus(open_bus)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int s0, input int s1, input int s2, input int t0, input int t1);
    bank_sel   = {8'(s2), 8'(s1), 8'(s0)};
    ram_status = {2'(t1), 2'(t0)};
  endtask

  // Bench's own view of the window table and the access rules.
  function automatic void model(input int a, input int s0, input int s1, input int s2,
                                input int t0, input int t1,
                                output bit ext, output bit wr, output int st,
                                output int pa, output int woff, output string tag);
    int bank;
    ext = 0; wr = 0; st = 0; pa = 0; woff = 0; bank = 0;
    if (a < 'h6000)      begin tag = "R7"; end
    else if (a < 'h6800) begin tag = "R10"; wr = 1; st = t0; woff = a - 'h6000; end
    else if (a < 'h7000) begin tag = "R7"; end
    else if (a < 'h8000) begin tag = "R8"; ext = 1; st = t1; bank = s1 % 12; pa = bank*4096 + (a - 'h7000); end
    else if (a < 'hA000) begin tag = "R3"; ext = 1; st = 2; bank = (s0 % 12) & ~1; pa = bank*4096 + (a - 'h8000); end
    else if (a < 'hB000) begin tag = "R9"; ext = 1; st = 3; pa = 2*4096 + (a - 'hA000); end
    else if (a < 'hC000) begin tag = "R4"; ext = 1; st = t1; bank = s1 % 12; pa = bank*4096 + (a - 'hB000); end
    else if (a < 'hE000) begin tag = "R3"; ext = 1; st = 2; bank = (s2 % 12) & ~1; pa = bank*4096 + (a - 'hC000); end
    else                 begin tag = "R2"; ext = 1; st = 2; pa = 10*4096 + (a - 'hE000); end
  endfunction

  task automatic do_write(input int a, input int d, input bit exp_we, input int exp_addr,
                          input string tag);
    @(negedge clk);
    cpu_rd = 0; cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
    chk(mem_we == exp_we, tag, $sformatf("mem_we after write to %0h", a), mem_we, exp_we);
    if (exp_we) begin
      chk(mem_waddr == 16'(exp_addr), tag, "mem_waddr", mem_waddr, exp_addr);
      chk(mem_wdata == 8'(d), tag, "mem_wdata", mem_wdata, d);
    end
  endtask

  task automatic read_wram(input int a, input string tag);
    @(negedge clk);
    cpu_addr = 16'(a); cpu_rd = 1;
    #1;
    chk(cpu_rdata == wram_model[a - 'h6000], tag, $sformatf("work RAM read %0h", a),
        cpu_rdata, wram_model[a - 'h6000]);
    cpu_rd = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit ext, wr; int st, pa, woff; string tag;
    for (int i = 0; i < 2048; i++) begin written[i] = 0; wram_model[i] = 8'h00; end

    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_we == 0, "R11", "mem_we in reset", mem_we, 0);
    chk(!open_bus && !rd_zero, "R11", "flags in reset", {open_bus, rd_zero}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_we == 0, "R11", "mem_we after reset", mem_we, 0);
    cpu_addr = 16'h6900; cpu_rd = 0; #1;
    chk(!open_bus && !rd_zero, "R11", "flags idle with cpu_rd low", {open_bus, rd_zero}, 0);

    // Fill work RAM at every address the sweep visits (R10)
    set_cfg(5, 5, 7, 3, 3);
    for (int k = 0; k < 32; k++) begin
      for (int e = 0; e < 2; e++) begin
        int a;
        a = 'h6000 + k*'h40 + e*'h3F;
        do_write(a, (a & 255) ^ 'h5A, 0, 0, "R10");
        wram_model[a - 'h6000] = 8'((a & 255) ^ 'h5A);
        written[a - 'h6000] = 1;
      end
    end

    // Directed writes
    do_write('hA123, 'h11, 1, 'h2123, "R9");
    do_write('hB010, 'h22, 1, 'h5010, "R5");
    set_cfg(5, 5, 7, 3, 2); do_write('hB010, 'h23, 0, 0, "R5");
    set_cfg(5, 5, 7, 3, 1); do_write('hB010, 'h24, 0, 0, "R5");
    set_cfg(5, 5, 7, 3, 0); do_write('hB010, 'h25, 0, 0, "R5");
    set_cfg(5, 5, 7, 3, 3); do_write('h7ABC, 'h33, 1, 'h5ABC, "R8");
    set_cfg(5, 5, 7, 3, 2); do_write('h7ABC, 'h34, 0, 0, "R8");
    do_write('h8000, 'h44, 0, 0, "R6");
    do_write('hF000, 'h45, 0, 0, "R6");
    do_write('h6900, 'h55, 0, 0, "R7");
    do_write('h5000, 'h56, 0, 0, "R7");
    set_cfg(5, 5, 7, 2, 3);
    do_write('h6040, 'hEE, 0, 0, "R10");
    read_wram('h6040, "R10");
    set_cfg(5, 5, 7, 3, 3);
    do_write('h6040, 'hEE, 0, 0, "R10");
    wram_model['h40] = 8'hEE;
    read_wram('h6040, "R10");

    // Sweep: two bank-select sets x all status pairs x block edges (R1..R4, R7..R10)
    for (int cs = 0; cs < 2; cs++) begin
      for (int t0 = 0; t0 < 4; t0++) begin
        for (int t1 = 0; t1 < 4; t1++) begin
          int s0, s1, s2;
          s0 = (cs == 0) ? 5 : 255;
          s1 = (cs == 0) ? 14 : 3;
          s2 = (cs == 0) ? 7 : 200;
          @(negedge clk);
          set_cfg(s0, s1, s2, t0, t1);
          cpu_rd = 1;
          for (int k = 0; k < 641; k++) begin
            for (int e = 0; e < 2; e++) begin
              int a; bit e_ob, e_zero, dchk; int e_addr, e_data;
              a = 'h5FC0 + k*'h40 + e*'h3F;
              model(a, s0, s1, s2, t0, t1, ext, wr, st, pa, woff, tag);
              e_ob   = (st == 0);
              e_zero = (st == 1);
              e_addr = ext ? pa : 0;
              e_data = 0;
              dchk   = 1;
              if (st >= 2) begin
                if (wr) begin dchk = written[woff]; e_data = int'(wram_model[woff]); end
                else e_data = (pa & 255) ^ ((pa >> 8) & 255);
              end
              cpu_addr = 16'(a);
              #1;
              chk((open_bus == e_ob) && (rd_zero == e_zero) && (mem_addr == 16'(e_addr)) &&
                  (!dchk || (cpu_rdata == 8'(e_data))),
                  {"R1,", tag}, $sformatf("addr %0h cfg %0d/%0d/%0d {ob,zero,maddr,data}", a, cs, t0, t1),
                  {open_bus, rd_zero, mem_addr, cpu_rdata},
                  {e_ob, e_zero, 16'(e_addr), dchk ? 8'(e_data) : cpu_rdata});
            end
          end
          cpu_rd = 0;
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule